// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the register bank that a host uses to drive a block-oriented hash engine over a simple 32-bit register bus. It holds the message block that the host loads word by word. It turns writes to a command register into single-cycle start requests for the engine, and it reports engine progress through a status word. When the engine finishes, the block keeps a copy of the engine's digest, and the host reads that copy through a word window.

Three read-only identification words sit at the bottom of the map. The command register carries a two-bit variant selector, and that selector also sets how many digest words can be read. A typical message of many blocks runs as follows: load a block, issue a first-block command, poll status, load the next block, issue a follow-on command, and repeat. Each bus access takes one cycle. Read data and the error flag are registered, so both appear on the cycle after the access.

Top module: `hash_reg_frontend`

## Requirements
- R1: Reads of address 0x00, 0x01 and 0x02 return the fixed words "dgst", "-reg" and "1.02" as ASCII, first character in bits 31:24. A write to any of these addresses changes nothing and sets the error flag.
- R2: A write to 0x08 while ready is 1 is accepted when write bit 0 (first block) or bit 1 (follow-on) is set. The cycle after an accepted write, eng_start is high for exactly one cycle, eng_init equals bit 0 (bit 0 wins when both bits are set) and eng_mode equals bits 3:2. A read of 0x08 returns the accepted mode in bits 3:2 and zeros elsewhere. The mode resets to 0.
- R3: A write to 0x08 while ready is 0, or a write with both command bits clear, starts nothing and leaves the mode unchanged.
- R4: A read of 0x09 returns ready in bit 0 and digest-valid in bit 1. After reset ready is 1 and valid is 0. Both read 0 from the cycle after a command is accepted. Both read 1 from the cycle after eng_done is seen while ready is 0. eng_done seen while ready is 1 is ignored.
- R5: Addresses 0x10 to 0x2F hold 32 writable block words, and each reads back what was last written to it. Word k drives eng_block bits [32*(31-k)+31 : 32*(31-k)], so word 0 is most significant.
- R6: When eng_done is accepted, the 16-word eng_digest (word 0 most significant) is captured. Addresses 0x40 to 0x4F return the captured word k. The readable count follows the mode: 7, 8, 12 or 16 words for modes 0, 1, 2 or 3. A read past that count returns zero and sets the error flag. A write anywhere in the window sets the error flag.
- R7: An access to any other address (0x03 to 0x07, 0x0A to 0x0F, 0x30 to 0x3F, 0x50 to 0xFF) sets the error flag. A read of such an address returns zero, and a write to it has no effect.
- R8: bus_error is high for exactly the one cycle after an erroneous access and is low at every other time. Writes to 0x09 are erroneous.
- R9: read_data changes only on the cycle after a read and holds its value until the next read. It is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| write_data | input | 32 | Write data |
| read_data | output | 32 | Registered read data |
| bus_error | output | 1 | One-cycle error flag for the previous access |
| eng_start | output | 1 | Start pulse to the engine |
| eng_init | output | 1 | Start is the first block of a message |
| eng_mode | output | 2 | Digest variant selector |
| eng_block | output | 1024 | Current block buffer contents |
| eng_done | input | 1 | Engine finished the block |
| eng_digest | input | 512 | Engine digest, valid with eng_done |

## Verification
The assertions assume that the engine raises eng_done only while a command is outstanding, and that eng_block stays stable while the engine is working. The bench's engine stub meets both conditions. It copies eng_block in the start cycle and answers after a fixed delay, and a second command can be accepted only after that delay. The assertions also assume that cs is low during reset, which the bench ensures by holding every bus input at zero until reset is released. The stimulus sends commands while the engine is busy and reads and writes outside the map. It includes back-to-back accesses with no idle cycle, so each error pulse is checked against the access that caused it.

// File: rtl/hash_reg_pkg.sv
package hash_reg_pkg;

    localparam int ADDR_CTRL = 8;
    localparam int ADDR_STAT = 9;

    localparam logic [31:0] ID_WORD0 = "dgst";
    localparam logic [31:0] ID_WORD1 = "-reg";
    localparam logic [31:0] ID_WORD2 = "1.02";

    typedef enum logic [2:0] {
        RG_ID, RG_CTRL, RG_STAT, RG_BLK, RG_DIG, RG_NONE
    } region_e;

    typedef struct packed {
        logic        ready;
        logic        valid;
        logic [1:0]  mode;
        logic        start;
        logic        init;
        logic [31:0] rdata;
        logic        err;
    } fe_state_t;

    // readable digest words for a mode, limited to the window size
    function automatic int active_words(input logic [1:0] mode, input int cap);
        int n;
        case (mode)
            2'd0:    n = 7;
            2'd1:    n = 8;
            2'd2:    n = 12;
            default: n = 16;
        endcase
        return (n < cap) ? n : cap;
    endfunction

endpackage

// File: rtl/hash_reg_decode.sv
module hash_reg_decode
    import hash_reg_pkg::*;
#(
    parameter int BLK_BASE  = 16,
    parameter int BLK_WORDS = 32,
    parameter int DIG_BASE  = 64,
    parameter int DIG_WORDS = 16,
    parameter int IW        = 5
) (
    input  logic [7:0]    addr,
    output region_e       region,
    output logic [IW-1:0] idx
);
    int a;

    always_comb begin
        a      = int'(addr);
        region = RG_NONE;
        idx    = '0;
        if (a <= 2) begin
            region = RG_ID;
            idx    = IW'(a);
        end else if (a == ADDR_CTRL) begin
            region = RG_CTRL;
        end else if (a == ADDR_STAT) begin
            region = RG_STAT;
        end else if (a >= BLK_BASE && a < BLK_BASE + BLK_WORDS) begin
            region = RG_BLK;
            idx    = IW'(a - BLK_BASE);
        end else if (a >= DIG_BASE && a < DIG_BASE + DIG_WORDS) begin
            region = RG_DIG;
            idx    = IW'(a - DIG_BASE);
        end
    end
endmodule

// File: rtl/hash_reg_words.sv
module hash_reg_words #(
    parameter int WORDS = 32,
    parameter int IW    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [IW-1:0]      idx,
    input  logic [31:0]        wdata,
    output logic [WORDS*32-1:0] flat,
    output logic [31:0]        rword
);
    logic [31:0] mem_q [WORDS];
    logic [31:0] mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr) mem_d[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WORDS; k++) mem_q[k] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar k = 0; k < WORDS; k++) begin : g_pack
        assign flat[(WORDS-1-k)*32 +: 32] = mem_q[k];
    end

    assign rword = mem_q[idx];
endmodule

// File: rtl/hash_reg_digest.sv
module hash_reg_digest
    import hash_reg_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int IW    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WORDS*32-1:0] din,
    input  logic [IW-1:0]       idx,
    input  logic [1:0]          mode,
    output logic                in_range,
    output logic [31:0]         rword
);
    logic [31:0] dig_q [WORDS];
    logic [31:0] dig_d [WORDS];
    logic [31:0] din_w [WORDS];

    for (genvar k = 0; k < WORDS; k++) begin : g_split
        assign din_w[k] = din[(WORDS-1-k)*32 +: 32];
    end

    always_comb begin
        dig_d = load ? din_w : dig_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WORDS; k++) dig_q[k] <= '0;
        end else begin
            dig_q <= dig_d;
        end
    end

    assign in_range = int'(idx) < active_words(mode, WORDS);
    assign rword    = in_range ? dig_q[idx] : 32'd0;
endmodule

// File: rtl/hash_reg_frontend.sv
module hash_reg_frontend
    import hash_reg_pkg::*;
#(
    parameter int BLOCK_WORDS  = 32,
    parameter int DIGEST_WORDS = 16,
    parameter int BLK_BASE     = 16,
    parameter int DIG_BASE     = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs,
    input  logic                       we,
    input  logic [7:0]                 addr,
    input  logic [31:0]                write_data,
    output logic [31:0]                read_data,
    output logic                       bus_error,
    output logic                       eng_start,
    output logic                       eng_init,
    output logic [1:0]                 eng_mode,
    output logic [BLOCK_WORDS*32-1:0]  eng_block,
    input  logic                       eng_done,
    input  logic [DIGEST_WORDS*32-1:0] eng_digest
);
    localparam int MAXW = (BLOCK_WORDS > DIGEST_WORDS) ? BLOCK_WORDS : DIGEST_WORDS;
    localparam int IW   = $clog2(MAXW);

    region_e       region;
    logic [IW-1:0] idx;
    logic          blk_wr;
    logic          dig_load;
    logic          dig_ok;
    logic [31:0]   blk_word;
    logic [31:0]   dig_word;
    fe_state_t     st_q, st_d;

    hash_reg_decode #(
        .BLK_BASE(BLK_BASE), .BLK_WORDS(BLOCK_WORDS),
        .DIG_BASE(DIG_BASE), .DIG_WORDS(DIGEST_WORDS), .IW(IW)
    ) u_dec (
        .addr(addr), .region(region), .idx(idx)
    );

    hash_reg_words #(.WORDS(BLOCK_WORDS), .IW(IW)) u_blk (
        .clk(clk), .rst_n(rst_n), .wr(blk_wr), .idx(idx),
        .wdata(write_data), .flat(eng_block), .rword(blk_word)
    );

    hash_reg_digest #(.WORDS(DIGEST_WORDS), .IW(IW)) u_dig (
        .clk(clk), .rst_n(rst_n), .load(dig_load), .din(eng_digest),
        .idx(idx), .mode(st_q.mode), .in_range(dig_ok), .rword(dig_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.err   = 1'b0;
        blk_wr     = 1'b0;
        dig_load   = 1'b0;

        if (eng_done && !st_q.ready) begin
            st_d.ready = 1'b1;
            st_d.valid = 1'b1;
            dig_load   = 1'b1;
        end

        if (cs && we) begin
            case (region)
                RG_CTRL: begin
                    if (st_q.ready && (write_data[1:0] != 2'b00)) begin
                        st_d.start = 1'b1;
                        st_d.init  = write_data[0];
                        st_d.mode  = write_data[3:2];
                        st_d.ready = 1'b0;
                        st_d.valid = 1'b0;
                    end
                end
                RG_BLK:  blk_wr   = 1'b1;
                default: st_d.err = 1'b1;
            endcase
        end else if (cs) begin
            case (region)
                RG_ID: begin
                    case (idx[1:0])
                        2'd0:    st_d.rdata = ID_WORD0;
                        2'd1:    st_d.rdata = ID_WORD1;
                        default: st_d.rdata = ID_WORD2;
                    endcase
                end
                RG_CTRL: st_d.rdata = {28'd0, st_q.mode, 2'b00};
                RG_STAT: st_d.rdata = {30'd0, st_q.valid, st_q.ready};
                RG_BLK:  st_d.rdata = blk_word;
                RG_DIG: begin
                    st_d.rdata = dig_word;
                    st_d.err   = !dig_ok;
                end
                default: begin
                    st_d.rdata = 32'd0;
                    st_d.err   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ready <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign read_data = st_q.rdata;
    assign bus_error = st_q.err;
    assign eng_start = st_q.start;
    assign eng_init  = st_q.init;
    assign eng_mode  = st_q.mode;

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && addr == 8'(ADDR_CTRL) && !st_q.ready) |=> !eng_start);

    // R4
    done_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !st_q.ready) |=> (st_q.ready && st_q.valid));

    // R8
    err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_error |-> $past(cs));

    // R7
    err_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_error && !$past(we)) |-> (read_data == 32'd0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !we) |=> $stable(read_data));
endmodule

// File: tb/tb_hash_reg_frontend.sv
module tb_hash_reg_frontend;
    localparam int BW  = 32;
    localparam int DW  = 16;
    localparam int LAT = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs = 1'b0, we = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     read_data;
    logic            bus_error, eng_start, eng_init;
    logic [1:0]      eng_mode;
    logic [BW*32-1:0] eng_block;
    logic            eng_done = 1'b0;
    logic [DW*32-1:0] eng_digest = '0;

    int checks = 0, errors = 0;
    bit finished = 0;

    hash_reg_frontend dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
        .write_data(wdata), .read_data(read_data), .bus_error(bus_error),
        .eng_start(eng_start), .eng_init(eng_init), .eng_mode(eng_mode),
        .eng_block(eng_block), .eng_done(eng_done), .eng_digest(eng_digest)
    );

    always #10 clk = ~clk;

    // ---------------- reference model ----------------
    logic [31:0] m_blk [BW];
    logic [31:0] m_dig [DW];
    logic        m_ready, m_valid, m_init;
    logic [1:0]  m_mode;
    logic [31:0] exp_rd;
    logic        exp_err, exp_start;
    string       exp_tag;
    int          starts_seen;

    function automatic int words_for(input logic [1:0] m);
        case (m)
            2'd0: return 7;
            2'd1: return 8;
            2'd2: return 12;
            default: return 16;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < BW; k++) m_blk[k] = '0;
            for (int k = 0; k < DW; k++) m_dig[k] = '0;
            m_ready = 1; m_valid = 0; m_init = 0; m_mode = 0;
            exp_rd = 0; exp_err = 0; exp_start = 0; exp_tag = "R9";
            starts_seen = 0;
        end else begin
            int a;
            a = int'(addr);
            exp_start = 0;
            exp_err   = 0;
            if (cs && !we) begin
                if (a == 0)      begin exp_rd = 32'h64677374; exp_tag = "R1 R9"; end
                else if (a == 1) begin exp_rd = 32'h2d726567; exp_tag = "R1 R9"; end
                else if (a == 2) begin exp_rd = 32'h312e3032; exp_tag = "R1 R9"; end
                else if (a == 8) begin exp_rd = {28'd0, m_mode, 2'b00}; exp_tag = "R2"; end
                else if (a == 9) begin exp_rd = {30'd0, m_valid, m_ready}; exp_tag = "R4"; end
                else if (a >= 16 && a < 16 + BW) begin exp_rd = m_blk[a-16]; exp_tag = "R5"; end
                else if (a >= 64 && a < 64 + DW) begin
                    exp_tag = "R6";
                    if (a - 64 < words_for(m_mode)) exp_rd = m_dig[a-64];
                    else begin exp_rd = 0; exp_err = 1; end
                end else begin exp_rd = 0; exp_err = 1; exp_tag = "R7"; end
            end
            if (cs && we) begin
                if (a == 8) begin
                    if (m_ready && wdata[1:0] != 2'b00) begin
                        exp_start = 1; m_init = wdata[0]; m_mode = wdata[3:2];
                        m_ready = 0; m_valid = 0; starts_seen++;
                    end
                end else if (a >= 16 && a < 16 + BW) m_blk[a-16] = wdata;
                else exp_err = 1;
            end
            if (eng_done && !m_ready) begin
                m_ready = 1; m_valid = 1;
                for (int k = 0; k < DW; k++) m_dig[k] = eng_digest[(DW-1-k)*32 +: 32];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(read_data === exp_rd, exp_tag, "read_data", 64'(read_data), 64'(exp_rd));
            chk(bus_error === exp_err, "R8", "bus_error", 64'(bus_error), 64'(exp_err));
            chk(eng_start === exp_start, "R2/R3", "eng_start", 64'(eng_start), 64'(exp_start));
            if (exp_start) begin
                logic [BW*32-1:0] pk;
                for (int k = 0; k < BW; k++) pk[(BW-1-k)*32 +: 32] = m_blk[k];
                chk(eng_init === m_init, "R2", "eng_init", 64'(eng_init), 64'(m_init));
                chk(eng_mode === m_mode, "R2", "eng_mode", 64'(eng_mode), 64'(m_mode));
                chk(eng_block === pk, "R5", "eng_block", eng_block[63:0], pk[63:0]);
            end
        end
    end

    // ---------------- engine stub ----------------
    int          stub_cnt = 0;
    logic        stub_init;
    logic [31:0] stub_w [BW];
    logic [31:0] chain [DW];

    always @(negedge clk) begin
        eng_done <= 1'b0;
        if (rst_n && eng_start) begin
            stub_cnt  = LAT;
            stub_init = eng_init;
            for (int k = 0; k < BW; k++) stub_w[k] = eng_block[(BW-1-k)*32 +: 32];
        end else if (stub_cnt > 0) begin
            stub_cnt--;
            if (stub_cnt == 0) begin
                logic [DW*32-1:0] dg;
                for (int k = 0; k < DW; k++) begin
                    chain[k] = ((stub_init ? 32'h5be0cd19 : chain[k]) ^
                                (stub_w[k] + stub_w[k+16])) + 32'(k);
                    dg[(DW-1-k)*32 +: 32] = chain[k];
                end
                eng_digest <= dg;
                eng_done   <= 1'b1;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int a, input logic [31:0] d);
        cs = 1; we = 1; addr = 8'(a); wdata = d;
        @(negedge clk);
        cs = 0; we = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] r);
        cs = 1; we = 0; addr = 8'(a);
        @(negedge clk);
        cs = 0;
        r = read_data;
    endtask

    task automatic wait_ready();
        logic [31:0] r;
        r = 0;
        for (int n = 0; n < 200 && !r[0]; n++) rd(9, r);
    endtask

    task automatic load_block(input logic [31:0] seed);
        for (int k = 0; k < BW; k++) wr(16 + k, seed * 32'(k + 3) ^ 32'h9e3779b9);
    endtask

    task automatic read_digest();
        logic [31:0] r;
        for (int k = 0; k < DW; k++) rd(64 + k, r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R4 reset state, R1 identification
        rd(9, r); rd(0, r); rd(1, r); rd(2, r); rd(8, r);
        wr(0, 32'hffff_ffff); wr(2, 32'h0); rd(0, r); rd(2, r);
        wr(9, 32'h3); rd(9, r);
        // R7 unmapped, back to back
        rd(3, r); rd(7, r); rd(10, r); rd(15, r); rd(48, r); rd(63, r); rd(80, r); rd(255, r);
        wr(5, 32'h1234); wr(48, 32'h1); wr(255, 32'h2); rd(0, r);
        // R3 command with no bits
        wr(8, 32'h0000_000c); rd(8, r);
        // R5 block buffer
        load_block(32'h1111); rd(16, r); rd(31, r); rd(47, r);
        // R2 first block mode 3
        wr(8, 32'h0000_000d);
        rd(9, r);
        wr(8, 32'h0000_0002);   // R3 busy, ignored
        wr(8, 32'h0000_0001);
        rd(8, r);
        wait_ready(); rd(9, r); read_digest();
        // follow-on blocks
        for (int b = 0; b < 4; b++) begin
            load_block(32'(b + 7));
            wr(8, 32'h0000_000e);
            wait_ready();
            read_digest();
        end
        // modes 0, 1, 2 with window limits (R6)
        for (int m = 0; m < 3; m++) begin
            load_block(32'(m + 40));
            wr(8, 32'(1 + (m << 2)));
            wait_ready(); read_digest(); rd(8, r);
            wr(64, 32'h5); wr(71, 32'h5);
        end
        // both command bits: first block wins
        wr(8, 32'h0000_0007);
        wait_ready(); read_digest();
        // write during busy to block buffer, then idle
        wr(8, 32'h0000_0002); wr(20, 32'hdead_beef); rd(20, r);
        wait_ready(); rd(9, r);
        repeat (5) @(negedge clk);
        checks++;
        if (starts_seen < 10) begin
            errors++;
            $display("FAIL R2: actual %0d starts expected at least 10", starts_seen);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule